// File: doc/BRIEF.md
# Nibble-Organised Subroutine Stack Engine

This block runs the subroutine and save/restore stack of a small 4-bit processor whose program counter is 14 bits wide. The stack sits in a 4-bit-wide data RAM and grows downward from an 8-bit stack pointer. The processor issues one command at a time: near call, far call, return, return-and-skip, return-from-interrupt, push or pop of a register pair, and push or pop of the two bank-select nibbles. The engine breaks each frame into nibbles and moves one nibble per clock through a single RAM port. Each nibble goes to a fixed offset from the stack pointer. When the last nibble has moved, the engine updates the pointer and the restored state, then raises a one-cycle done strobe.

Call frames are four nibbles in a non-sequential layout. Bits 11:8 of the program counter sit at the lowest address. Bits 7:4 and 3:0 sit at the two highest addresses. A packed nibble holding the two memory/register-bank enable flags and PC[13:12] lies between them. Interrupt frames add a two-nibble status word above the call frame. The stack pointer is kept inside the block, starts at a reset value and wraps modulo 256.

Top module: `nibble_stack_engine`

## Requirements
- R1: After reset, `sp` equals the reset value (0 by default), and `busy`, `done`, `skip` and `err` are 0, and `pc_out`, `psw_out`, `rp_out`, `mbs_out`, `rbs_out`, `mbe_out` and `rbe_out` are 0.
- R2: A call (op 1 or 2) writes PC[7:4] to SP-1, PC[3:0] to SP-2, {MBE, RBE, PC[13], PC[12]} (MBE in bit 3) to SP-3 and PC[11:8] to SP-4, where PC, MBE and RBE are the values presented with the command. It then lowers SP by 4.
- R3: A near call (op 1) loads `pc_out` with the 14-bit target. A far call (op 2) loads it with two zero bits above the 12-bit far address.
- R4: A return (op 3) loads {MBE, RBE, PC[13:12]} from SP+1 and PC[11:0] from SP, SP+3 and SP+2 (most significant first). It then raises SP by 4.
- R5: Return-and-skip (op 4) restores state exactly as a return does and asserts `skip` together with `done`. No other command asserts `skip`.
- R6: Return-from-interrupt (op 5) loads PC[13:12] from bits 1:0 of SP+1 and PC[11:0] as a return does. It loads `psw_out` with SP+4 as the high nibble and SP+5 as the low nibble, and raises SP by 6. MBE and RBE keep their values.
- R7: Register-pair push (op 6) writes the high nibble to SP-1 and the low nibble to SP-2, then lowers SP by 2. Pop (op 7) loads the high nibble from SP+1 and the low nibble from SP, then raises SP by 2.
- R8: Bank-select push (op 8) writes the memory-bank select to SP-1 and the register-bank select to SP-2, then lowers SP by 2. Pop (op 9) restores them from SP+1 and SP respectively, then raises SP by 2.
- R9: Exactly one RAM access happens per clock while busy, and none while idle. `done` is a one-cycle pulse, visible N+1 cycles after the accepting edge, where N is the frame length in nibbles (4 for calls and returns, 6 for interrupt return, 2 for push and pop). SP does not change before that.
- R10: A command presented while busy is ignored, and `err` pulses in the following cycle.
- R11: An opcode outside 1 to 9 presented while idle does nothing: no RAM write, no `done`, no `err`, and `sp` is unchanged.
- R12: SP arithmetic wraps modulo 256. A call from SP 0 uses addresses 0xFF down to 0xFC and leaves SP at 0xFC.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 4 | Command code (1 call, 2 far call, 3 return, 4 return-and-skip, 5 interrupt return, 6/7 pair push/pop, 8/9 bank push/pop) |
| pc_in | input | 14 | Return address to save on a call |
| call_target | input | 14 | Near call destination |
| far_target | input | 12 | Far call destination |
| mbe_in | input | 1 | Memory-bank enable flag to save |
| rbe_in | input | 1 | Register-bank enable flag to save |
| rp_in | input | 8 | Register pair to push |
| mbs_in | input | 4 | Memory-bank select to push |
| rbs_in | input | 4 | Register-bank select to push |
| mem_addr | output | 8 | RAM nibble address |
| mem_we | output | 1 | RAM write enable |
| mem_wdata | output | 4 | RAM write nibble |
| mem_rdata | input | 4 | RAM read nibble (combinational read of mem_addr) |
| sp | output | 8 | Stack pointer |
| pc_out | output | 14 | Loaded or restored program counter |
| mbe_out | output | 1 | Restored memory-bank enable |
| rbe_out | output | 1 | Restored register-bank enable |
| psw_out | output | 8 | Restored status word |
| rp_out | output | 8 | Popped register pair |
| mbs_out | output | 4 | Popped memory-bank select |
| rbs_out | output | 4 | Popped register-bank select |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion strobe |
| skip | output | 1 | Skip next instruction, with done |
| err | output | 1 | Pulse for a command rejected while busy |

## Verification
The assertions check the cycle-level rules on every cycle. There is no RAM write while idle, and `done` never lasts two cycles. `skip` appears only with `done`. The pointer holds until the completing edge. A command issued while busy raises `err` one cycle later and leaves the latched operation unchanged. Only the bench scenarios can show that the nibbles land at the stated offsets in the stated order. They also show that calls and pushes round-trip through returns and pops bit-exactly, that the pointer wraps at zero and returns to its start, and that the interrupt frame restores the status word while leaving the enable flags alone.

// File: rtl/nse_pkg.sv
package nse_pkg;
   localparam int NIB_W    = 4;
   localparam int MAX_NIBS = 6;
   localparam int STEP_W   = $clog2(MAX_NIBS);

   typedef enum logic [3:0] {
      OP_NONE   = 4'd0,
      OP_CALL   = 4'd1,
      OP_CALLF  = 4'd2,
      OP_RET    = 4'd3,
      OP_RETS   = 4'd4,
      OP_RETI   = 4'd5,
      OP_PUSHRP = 4'd6,
      OP_POPRP  = 4'd7,
      OP_PUSHBS = 4'd8,
      OP_POPBS  = 4'd9
   } stk_op_e;

   function automatic logic op_known(input logic [3:0] op);
      return (op >= 4'd1) && (op <= 4'd9);
   endfunction

   function automatic logic op_writes(input stk_op_e op);
      return (op == OP_CALL) || (op == OP_CALLF) ||
             (op == OP_PUSHRP) || (op == OP_PUSHBS);
   endfunction

   function automatic logic [STEP_W-1:0] op_nibs(input stk_op_e op);
      case (op)
         OP_CALL, OP_CALLF, OP_RET, OP_RETS: return STEP_W'(4);
         OP_RETI:                            return STEP_W'(6);
         default:                            return STEP_W'(2);
      endcase
   endfunction
endpackage

// File: rtl/nse_seq.sv
module nse_seq
   import nse_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_valid,
   input  logic [3:0]        cmd_op,
   output logic              busy,
   output logic [STEP_W-1:0] step,
   output logic              last,
   output stk_op_e           op_q,
   output logic              err
);
   logic start;

   assign start = cmd_valid && !busy && op_known(cmd_op);
   assign last  = busy && (step == op_nibs(op_q) - STEP_W'(1));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy <= 1'b0;
         step <= '0;
         op_q <= OP_NONE;
         err  <= 1'b0;
      end else begin
         err <= cmd_valid && busy;
         if (!busy) begin
            if (start) begin
               busy <= 1'b1;
               step <= '0;
               op_q <= stk_op_e'(cmd_op);
            end
         end else if (last) begin
            busy <= 1'b0;
         end else begin
            step <= step + STEP_W'(1);
         end
      end
   end

   a_r10_err_after_busy_cmd: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid && busy |=> err);
   a_r10_op_held: assert property (@(posedge clk) disable iff (!rst_n)
      busy && !last |=> $stable(op_q));
endmodule

// File: rtl/nse_frame.sv
module nse_frame
   import nse_pkg::*;
#(
   parameter int PC_W = 14,
   parameter int SP_W = 8
) (
   input  logic              busy,
   input  stk_op_e           op,
   input  logic [STEP_W-1:0] step,
   input  logic [SP_W-1:0]   sp,
   input  logic [PC_W-1:0]   pc,
   input  logic              mbe,
   input  logic              rbe,
   input  logic [7:0]        rp,
   input  logic [NIB_W-1:0]  mbs,
   input  logic [NIB_W-1:0]  rbs,
   output logic [SP_W-1:0]   mem_addr,
   output logic              mem_we,
   output logic [NIB_W-1:0]  mem_wdata
);
   logic            wr_op;
   logic [SP_W-1:0] step_ext;

   assign wr_op    = op_writes(op);
   assign step_ext = SP_W'(step);
   assign mem_we   = busy && wr_op;
   assign mem_addr = wr_op ? sp - step_ext - SP_W'(1) : sp + step_ext;

   always_comb begin
      mem_wdata = '0;
      case (op)
         OP_CALL, OP_CALLF: begin
            case (step)
               STEP_W'(0): mem_wdata = pc[7:4];
               STEP_W'(1): mem_wdata = pc[3:0];
               STEP_W'(2): mem_wdata = {mbe, rbe, pc[13:12]};
               default:    mem_wdata = pc[11:8];
            endcase
         end
         OP_PUSHRP: mem_wdata = (step == '0) ? rp[7:4] : rp[3:0];
         OP_PUSHBS: mem_wdata = (step == '0) ? mbs : rbs;
         default:   mem_wdata = '0;
      endcase
   end
endmodule

// File: rtl/nibble_stack_engine.sv
module nibble_stack_engine
   import nse_pkg::*;
#(
   parameter int              PC_W     = 14,
   parameter int              FAR_W    = 12,
   parameter int              SP_W     = 8,
   parameter logic [SP_W-1:0] SP_RESET = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cmd_valid,
   input  logic [3:0]       cmd_op,
   input  logic [PC_W-1:0]  pc_in,
   input  logic [PC_W-1:0]  call_target,
   input  logic [FAR_W-1:0] far_target,
   input  logic             mbe_in,
   input  logic             rbe_in,
   input  logic [7:0]       rp_in,
   input  logic [3:0]       mbs_in,
   input  logic [3:0]       rbs_in,
   output logic [SP_W-1:0]  mem_addr,
   output logic             mem_we,
   output logic [3:0]       mem_wdata,
   input  logic [3:0]       mem_rdata,
   output logic [SP_W-1:0]  sp,
   output logic [PC_W-1:0]  pc_out,
   output logic             mbe_out,
   output logic             rbe_out,
   output logic [7:0]       psw_out,
   output logic [7:0]       rp_out,
   output logic [3:0]       mbs_out,
   output logic [3:0]       rbs_out,
   output logic             busy,
   output logic             done,
   output logic             skip,
   output logic             err
);
   localparam int PC_LO_W = 3 * NIB_W;

   if (PC_W != PC_LO_W + 2) begin : g_bad_pc
      $error("PC_W must be three nibbles plus two bits");
   end
   if (SP_W < 3) begin : g_bad_sp
      $error("SP_W too small for a six-nibble frame");
   end

   logic [PC_W-1:0] far_ext;
   if (FAR_W < PC_W) begin : g_far_pad
      assign far_ext = {{(PC_W-FAR_W){1'b0}}, far_target_q};
   end else begin : g_far_bad
      assign far_ext = '0;
      $error("FAR_W must be narrower than PC_W");
   end

   logic [STEP_W-1:0] step;
   logic              last;
   stk_op_e           op_q;
   logic              accept;
   logic [PC_W-1:0]   pc_q, tgt_q;
   logic [FAR_W-1:0]  far_target_q;
   logic              mbe_q, rbe_q;
   logic [7:0]        rp_q;
   logic [3:0]        mbs_q, rbs_q;
   logic [3:0]        nib_q   [MAX_NIBS];
   logic [3:0]        nib_now [MAX_NIBS];

   assign accept = cmd_valid && !busy && op_known(cmd_op);

   nse_seq u_seq (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
      .busy(busy), .step(step), .last(last), .op_q(op_q), .err(err)
   );

   nse_frame #(.PC_W(PC_W), .SP_W(SP_W)) u_frame (
      .busy(busy), .op(op_q), .step(step), .sp(sp), .pc(pc_q),
      .mbe(mbe_q), .rbe(rbe_q), .rp(rp_q), .mbs(mbs_q), .rbs(rbs_q),
      .mem_addr(mem_addr), .mem_we(mem_we), .mem_wdata(mem_wdata)
   );

   for (genvar g = 0; g < MAX_NIBS; g++) begin : g_nib
      assign nib_now[g] = (busy && step == STEP_W'(g)) ? mem_rdata : nib_q[g];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pc_q <= '0; tgt_q <= '0; far_target_q <= '0;
         mbe_q <= 1'b0; rbe_q <= 1'b0; rp_q <= '0; mbs_q <= '0; rbs_q <= '0;
         for (int i = 0; i < MAX_NIBS; i++) nib_q[i] <= '0;
      end else begin
         if (accept) begin
            pc_q <= pc_in; tgt_q <= call_target; far_target_q <= far_target;
            mbe_q <= mbe_in; rbe_q <= rbe_in;
            rp_q <= rp_in; mbs_q <= mbs_in; rbs_q <= rbs_in;
         end
         if (busy && !op_writes(op_q)) nib_q[step] <= mem_rdata;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sp <= SP_RESET; pc_out <= '0; mbe_out <= 1'b0; rbe_out <= 1'b0;
         psw_out <= '0; rp_out <= '0; mbs_out <= '0; rbs_out <= '0;
         done <= 1'b0; skip <= 1'b0;
      end else begin
         done <= last;
         skip <= last && (op_q == OP_RETS);
         if (last) begin
            case (op_q)
               OP_CALL:  begin pc_out <= tgt_q;   sp <= sp - SP_W'(4); end
               OP_CALLF: begin pc_out <= far_ext; sp <= sp - SP_W'(4); end
               OP_RET, OP_RETS: begin
                  {mbe_out, rbe_out, pc_out[PC_W-1:PC_LO_W]} <= nib_now[1];
                  pc_out[PC_LO_W-1:0] <= {nib_now[0], nib_now[3], nib_now[2]};
                  sp <= sp + SP_W'(4);
               end
               OP_RETI: begin
                  pc_out <= {nib_now[1][1:0], nib_now[0], nib_now[3], nib_now[2]};
                  psw_out <= {nib_now[4], nib_now[5]};
                  sp <= sp + SP_W'(6);
               end
               OP_PUSHRP, OP_PUSHBS: sp <= sp - SP_W'(2);
               OP_POPRP: begin rp_out <= {nib_now[1], nib_now[0]}; sp <= sp + SP_W'(2); end
               OP_POPBS: begin
                  mbs_out <= nib_now[1]; rbs_out <= nib_now[0]; sp <= sp + SP_W'(2);
               end
               default: ;
            endcase
         end
      end
   end

   a_r9_no_access_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !mem_we);
   a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   a_r9_sp_hold_busy: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> ($stable(sp) || done));
   a_r5_skip_with_done: assert property (@(posedge clk) disable iff (!rst_n)
      skip |-> done);
endmodule

// File: tb/nibble_stack_engine_bench.sv
module nibble_stack_engine_bench;
   typedef struct packed {
      logic [3:0]  op;
      logic [13:0] pc;
      logic [13:0] tgt;
      logic [11:0] far;
      logic        mbe;
      logic        rbe;
      logic [7:0]  rp;
      logic [3:0]  mbs;
      logic [3:0]  rbs;
   } vec_t;

   localparam int NV = 8;
   localparam vec_t VEC [NV] = '{
      '{4'd1, 14'h2ABC, 14'h0123, 12'h000, 1'b1, 1'b0, 8'h00, 4'h0, 4'h0},
      '{4'd6, 14'h0000, 14'h0000, 12'h000, 1'b0, 1'b0, 8'h5A, 4'h0, 4'h0},
      '{4'd8, 14'h0000, 14'h0000, 12'h000, 1'b0, 1'b0, 8'h00, 4'hE, 4'h3},
      '{4'd2, 14'h1D47, 14'h0000, 12'h9F1, 1'b0, 1'b1, 8'h00, 4'h0, 4'h0},
      '{4'd4, 14'h0000, 14'h0000, 12'h000, 1'b0, 1'b0, 8'h00, 4'h0, 4'h0},
      '{4'd9, 14'h0000, 14'h0000, 12'h000, 1'b0, 1'b0, 8'h00, 4'h0, 4'h0},
      '{4'd7, 14'h0000, 14'h0000, 12'h000, 1'b0, 1'b0, 8'h00, 4'h0, 4'h0},
      '{4'd3, 14'h0000, 14'h0000, 12'h000, 1'b0, 1'b0, 8'h00, 4'h0, 4'h0}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cmd_valid = 1'b0;
   logic [3:0]  cmd_op = '0;
   logic [13:0] pc_in = '0, call_target = '0;
   logic [11:0] far_target = '0;
   logic        mbe_in = 1'b0, rbe_in = 1'b0;
   logic [7:0]  rp_in = '0;
   logic [3:0]  mbs_in = '0, rbs_in = '0;
   logic [7:0]  mem_addr, sp, psw_out, rp_out;
   logic        mem_we, mbe_out, rbe_out, busy, done, skip, err;
   logic [3:0]  mem_wdata, mem_rdata, mbs_out, rbs_out;
   logic [13:0] pc_out;
   logic [3:0]  ram [256];
   int          checks = 0;
   int          errors = 0;

   always #4 clk = ~clk;

   always @(posedge clk) if (mem_we) ram[mem_addr] <= mem_wdata;
   assign mem_rdata = ram[mem_addr];

   nibble_stack_engine u_nibble_stack_engine (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
      .pc_in(pc_in), .call_target(call_target), .far_target(far_target),
      .mbe_in(mbe_in), .rbe_in(rbe_in), .rp_in(rp_in), .mbs_in(mbs_in),
      .rbs_in(rbs_in), .mem_addr(mem_addr), .mem_we(mem_we),
      .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .sp(sp), .pc_out(pc_out),
      .mbe_out(mbe_out), .rbe_out(rbe_out), .psw_out(psw_out), .rp_out(rp_out),
      .mbs_out(mbs_out), .rbs_out(rbs_out), .busy(busy), .done(done),
      .skip(skip), .err(err)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic int nibs_of(input logic [3:0] op);
      case (op)
         4'd1, 4'd2, 4'd3, 4'd4: return 4;
         4'd5:                   return 6;
         default:                return 2;
      endcase
   endfunction

   task automatic finish_run();
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   // issue one command from idle, wait for done, return cycles and old SP
   task automatic issue(input vec_t v, output int cyc, output logic [7:0] sp0);
      @(negedge clk);
      sp0 = sp;
      cmd_valid = 1'b1; cmd_op = v.op; pc_in = v.pc; call_target = v.tgt;
      far_target = v.far; mbe_in = v.mbe; rbe_in = v.rbe; rp_in = v.rp;
      mbs_in = v.mbs; rbs_in = v.rbs;
      @(negedge clk);
      cmd_valid = 1'b0;
      cyc = 1;
      while (!done && cyc < 30) begin
         @(negedge clk);
         cyc++;
      end
   endtask

   task automatic run_vec(input vec_t v);
      int         cyc;
      logic [7:0] s;
      logic [13:0] exp_pc;
      issue(v, cyc, s);
      chk("R9 done latency", 32'(cyc), 32'(nibs_of(v.op) + 1));
      chk("R5 skip only on return-and-skip", {31'b0, skip}, {31'b0, v.op == 4'd4});
      chk("R10 no err from idle command", {31'b0, err}, 32'd0);
      case (v.op)
         4'd1, 4'd2: begin
            chk("R2 frame SP-1", {28'b0, ram[s - 8'd1]}, {28'b0, v.pc[7:4]});
            chk("R2 frame SP-2", {28'b0, ram[s - 8'd2]}, {28'b0, v.pc[3:0]});
            chk("R2 frame SP-3", {28'b0, ram[s - 8'd3]}, {28'b0, v.mbe, v.rbe, v.pc[13:12]});
            chk("R2 frame SP-4", {28'b0, ram[s - 8'd4]}, {28'b0, v.pc[11:8]});
            chk("R2 sp minus 4", {24'b0, sp}, {24'b0, s - 8'd4});
            chk("R3 call target", {18'b0, pc_out},
                {18'b0, (v.op == 4'd1) ? v.tgt : {2'b00, v.far}});
         end
         4'd3, 4'd4: begin
            exp_pc = {ram[s + 8'd1][1:0], ram[s], ram[s + 8'd3], ram[s + 8'd2]};
            chk("R4 return pc", {18'b0, pc_out}, {18'b0, exp_pc});
            chk("R4 return flags", {30'b0, mbe_out, rbe_out}, {30'b0, ram[s + 8'd1][3:2]});
            chk("R4 sp plus 4", {24'b0, sp}, {24'b0, s + 8'd4});
         end
         4'd6: begin
            chk("R7 push pair", {24'b0, ram[s - 8'd1], ram[s - 8'd2]}, {24'b0, v.rp});
            chk("R7 sp minus 2", {24'b0, sp}, {24'b0, s - 8'd2});
         end
         4'd7: begin
            chk("R7 pop pair", {24'b0, rp_out}, {24'b0, ram[s + 8'd1], ram[s]});
            chk("R7 sp plus 2", {24'b0, sp}, {24'b0, s + 8'd2});
         end
         4'd8: begin
            chk("R8 push banks", {24'b0, ram[s - 8'd1], ram[s - 8'd2]}, {24'b0, v.mbs, v.rbs});
            chk("R8 sp minus 2", {24'b0, sp}, {24'b0, s - 8'd2});
         end
         4'd9: begin
            chk("R8 pop banks", {24'b0, mbs_out, rbs_out}, {24'b0, ram[s + 8'd1], ram[s]});
            chk("R8 sp plus 2", {24'b0, sp}, {24'b0, s + 8'd2});
         end
         default: ;
      endcase
   endtask

   initial begin
      #(8ns * 100000);
      errors++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      vec_t       v;
      int         cyc;
      logic [7:0] s;
      logic       m0, r0;
      for (int i = 0; i < 256; i++) ram[i] = 4'h0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk("R1 sp reset", {24'b0, sp}, 32'd0);
      chk("R1 flags idle", {28'b0, busy, done, skip, err}, 32'd0);
      chk("R1 outputs zero", {pc_out, psw_out, rp_out, 2'b00}, 32'd0);
      chk("R1 banks zero", {24'b0, mbs_out, rbs_out}, {24'b0, 4'h0, 4'h0});

      for (int i = 0; i < NV; i++) begin
         run_vec(VEC[i]);
         if (i == 0) begin
            chk("R12 wrap call uses 0xFC", {28'b0, ram[8'hFC]}, 32'hA);
            chk("R12 sp wrapped", {24'b0, sp}, 32'hFC);
         end
         if (i == 4) chk("R4 far frame round trip", {18'b0, pc_out, mbe_out, rbe_out},
                         {18'b0, 14'h1D47, 1'b0, 1'b1});
         if (i == 5) chk("R8 banks round trip", {24'b0, mbs_out, rbs_out}, 32'hE3);
         if (i == 6) chk("R7 pair round trip", {24'b0, rp_out}, 32'h5A);
      end
      chk("R4 call/return round trip pc", {18'b0, pc_out}, {18'b0, 14'h2ABC});
      chk("R4 call/return round trip flags", {30'b0, mbe_out, rbe_out}, 32'd2);
      chk("R12 sp back at start", {24'b0, sp}, 32'd0);

      // R6 interrupt return from a prepared frame
      ram[0] = 4'h7; ram[1] = 4'h6; ram[2] = 4'h1; ram[3] = 4'hC;
      ram[4] = 4'h9; ram[5] = 4'h4;
      m0 = mbe_out; r0 = rbe_out;
      v = '0; v.op = 4'd5;
      issue(v, cyc, s);
      chk("R6 latency", 32'(cyc), 32'd7);
      chk("R6 pc", {18'b0, pc_out}, {18'b0, 2'b10, 4'h7, 4'hC, 4'h1});
      chk("R6 psw", {24'b0, psw_out}, 32'h94);
      chk("R6 flags kept", {30'b0, mbe_out, rbe_out}, {30'b0, m0, r0});
      chk("R6 sp plus 6", {24'b0, sp}, 32'd6);

      // R10 command while busy is ignored
      @(negedge clk);
      s = sp;
      cmd_valid = 1'b1; cmd_op = 4'd6; rp_in = 8'h3C;
      @(negedge clk);
      cmd_op = 4'd7;
      @(negedge clk);
      cmd_valid = 1'b0;
      chk("R10 err pulse", {31'b0, err}, 32'd1);
      cyc = 0;
      while (!done && cyc < 30) begin @(negedge clk); cyc++; end
      chk("R10 only push done", {24'b0, sp}, {24'b0, s - 8'd2});
      chk("R10 pop ignored", {24'b0, rp_out}, 32'h5A);
      @(negedge clk);
      chk("R10 no second done", {30'b0, done, busy}, 32'd0);

      // R11 unknown opcode
      s = sp;
      @(negedge clk);
      cmd_valid = 1'b1; cmd_op = 4'hC;
      @(negedge clk);
      cmd_valid = 1'b0;
      chk("R11 not busy", {31'b0, busy}, 32'd0);
      repeat (6) @(negedge clk);
      chk("R11 no done or err", {30'b0, done, err}, 32'd0);
      chk("R11 sp unchanged", {24'b0, sp}, {24'b0, s});
      finish_run();
   end
endmodule